// File: doc/BRIEF.md
# Serial Memory Slave Command Engine

This block is the slave side of a small byte-addressed memory reached over a four-wire serial bus in clock mode 0 (clock idles low). A bus master lowers the active-low select, clocks in an 8-bit command, and then, depending on the command, sends or receives more bytes. Six commands are decoded. Two set and clear a write-enable flag. Two read and write an 8-bit status word. Two run streaming reads and writes into an internal byte array built from plain registers.

The select, clock and data inputs are synchronised into the system clock, and their edges are detected there. The master's clock must therefore stay well below the system clock; a half period of at least six system cycles is safe. A write-enable flag guards every write to the status word and to the array. It is set only by its own command, and it drops when select rises at the end of any frame that began with the write-disable, status-write or memory-write command.

The array holds 2^`MEM_AW` bytes. The default is 1 KiB, and `MEM_AW = 13` gives the full 8 KiB.

The command FSM has these states:
- `ST_OPCODE`: waiting for a command byte.
- `ST_ADDR_HI` and `ST_ADDR_LO`: collecting the two address bytes.
- `ST_STAT_RD` and `ST_STAT_WR`: status transfer.
- `ST_RD_DATA` and `ST_WR_DATA`: streaming data.
- `ST_IGNORE`: swallowing bytes until the frame ends.

Its transitions are:
- A rising select from any state goes to `ST_OPCODE`.
- From `ST_OPCODE`:
  - command 0x05 goes to `ST_STAT_RD`;
  - command 0x01 goes to `ST_STAT_WR`;
  - commands 0x03 and 0x02 go to `ST_ADDR_HI`;
  - 0x06, 0x04 and any unknown byte go to `ST_IGNORE`.
- `ST_ADDR_HI` goes to `ST_ADDR_LO`.
- `ST_ADDR_LO` goes to `ST_RD_DATA` or `ST_WR_DATA`.
- `ST_STAT_WR` goes to `ST_IGNORE` after one byte.
- The data states and `ST_STAT_RD` hold until select rises.

Top module: `sermem_slave`

## Requirements
- R1: All bytes, both commands and data, travel as 8-bit groups with the most significant bit first.
- R2: MOSI is sampled on rising edges of `sck`. MISO changes only after falling edges of `sck`, and it is 0 while the block is deselected.
- R3: After reset, the status word reads 0x00 (write-enable flag clear) and every array byte reads 0x00.
- R4: Command 0x06 sets the write-enable flag, which appears at status bit 1. Command 0x05 returns the status word for every byte clocked after it in the frame.
- R5: Command 0x04 clears the write-enable flag when select rises.
- R6: Command 0x01, with the flag set, stores data bits 7..2 into the status word. Data bit 1 cannot set the flag, status bit 0 always reads 0, and the flag clears when select rises.
- R7: A status write (0x01) or memory write (0x02) made while the flag is clear leaves the status word and the array unchanged.
- R8: Command 0x02 takes a 2-byte address (high byte first, only the low `MEM_AW` bits used) and then writes each further byte at consecutive addresses. The flag clears when select rises.
- R9: Command 0x03 takes a 2-byte address the same way and returns consecutive bytes. The address wraps from the top of the array to 0.
- R10: A select rise in the middle of a byte discards the partial byte, and the next frame decodes its first byte as a command.
- R11: An unknown command byte, and any byte after 0x06 or 0x04, is ignored until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low slave select from the master |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The bench goes after the write-enable flag's lifecycle: that it drops only at frame end after the right commands, that a status write cannot set it, and that writes made while it is clear are discarded. A design that cleared it on decode, or that let data bit 1 set it, would return the wrong status byte. Streaming reads run across the top of a small array, and a write burst crosses the top as well, so an address counter that saturates or runs too wide returns stale bytes. Frames cut off after seven bits, unknown commands followed by a valid one, and extra bytes after single-byte commands expose a decoder that keeps partial bits or resumes decoding inside a frame.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    localparam logic [7:0] OPC_WEN_SET = 8'h06;
    localparam logic [7:0] OPC_WEN_CLR = 8'h04;
    localparam logic [7:0] OPC_STAT_RD = 8'h05;
    localparam logic [7:0] OPC_STAT_WR = 8'h01;
    localparam logic [7:0] OPC_MEM_RD  = 8'h03;
    localparam logic [7:0] OPC_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_IGNORE
    } cmd_state_e;

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sermem_frontend.sv
module sermem_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       tx_load_i,
    input  logic [7:0] tx_data_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       frame_end_o,
    output logic       miso_o
);

    logic       cs_n_s, sck_s, mosi_s;
    logic       cs_n_q, sck_q;
    logic       sck_rise, sck_fall;
    logic [2:0] bit_cnt_q;
    logic [6:0] rx_sh_q;
    logic [7:0] tx_sh_q;
    logic       miso_q;
    logic       byte_vld_q;
    logic [7:0] byte_q;
    logic       frame_end_q;

    sermem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_n_s));
    sermem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
    sermem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_s));

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;

    // edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sck_q  <= 1'b0;
        end else begin
            cs_n_q <= cs_n_s;
            sck_q  <= sck_s;
        end
    end

    // receive path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_sh_q     <= '0;
            byte_vld_q  <= 1'b0;
            byte_q      <= '0;
            frame_end_q <= 1'b0;
        end else begin
            byte_vld_q  <= 1'b0;
            frame_end_q <= cs_n_s & ~cs_n_q;
            if (cs_n_s) begin
                bit_cnt_q <= '0;
                rx_sh_q   <= '0;
            end else if (sck_rise) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                rx_sh_q   <= {rx_sh_q[5:0], mosi_s};
                if (bit_cnt_q == 3'd7) begin
                    byte_vld_q <= 1'b1;
                    byte_q     <= {rx_sh_q, mosi_s};
                end
            end
        end
    end

    // transmit path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            miso_q  <= 1'b0;
        end else if (cs_n_s) begin
            tx_sh_q <= '0;
            miso_q  <= 1'b0;
        end else if (tx_load_i) begin
            tx_sh_q <= tx_data_i;
        end else if (sck_fall) begin
            miso_q  <= tx_sh_q[7];
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        end
    end

    assign byte_vld_o  = byte_vld_q;
    assign byte_o      = byte_q;
    assign frame_end_o = frame_end_q;
    assign miso_o      = miso_q;

    AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_q |=> !byte_vld_q); // R1
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_n_s) |=> ($stable(miso_q) || cs_n_s)); // R2
    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt_q == 3'd0 && !byte_vld_q)); // R10

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
    import sermem_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          frame_end_i,
    input  logic [7:0]    rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          tx_load_o,
    output logic [7:0]    tx_data_o
);

    cmd_state_e    state_q, state_d;
    logic          wel_q;
    logic          clr_q;
    logic          is_wr_q;
    logic [5:0]    stat_q;
    logic [7:0]    addr_hi_q;
    logic [AW-1:0] addr_q;
    logic          tx_load_q;
    logic [7:0]    tx_data_q;
    logic [15:0]   full_addr;
    logic [AW-1:0] start_addr;
    logic [7:0]    stat_word;

    assign full_addr  = {addr_hi_q, byte_i};
    assign start_addr = full_addr[AW-1:0];
    assign stat_word  = {stat_q, wel_q, 1'b0};

    generate
        if (AW < 16) begin : g_unused_hi
            logic unused_addr_bits;
            assign unused_addr_bits = ^full_addr[15:AW];
        end
    endgenerate

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_end_i) begin
            state_d = ST_OPCODE;
        end else if (byte_vld_i) begin
            unique case (state_q)
                ST_OPCODE: begin
                    case (byte_i)
                        OPC_STAT_RD: state_d = ST_STAT_RD;
                        OPC_STAT_WR: state_d = ST_STAT_WR;
                        OPC_MEM_RD:  state_d = ST_ADDR_HI;
                        OPC_MEM_WR:  state_d = ST_ADDR_HI;
                        default:     state_d = ST_IGNORE;
                    endcase
                end
                ST_ADDR_HI: state_d = ST_ADDR_LO;
                ST_ADDR_LO: state_d = is_wr_q ? ST_WR_DATA : ST_RD_DATA;
                ST_STAT_RD: state_d = ST_STAT_RD;
                ST_STAT_WR: state_d = ST_IGNORE;
                ST_RD_DATA: state_d = ST_RD_DATA;
                ST_WR_DATA: state_d = ST_WR_DATA;
                ST_IGNORE:  state_d = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            clr_q     <= 1'b0;
            is_wr_q   <= 1'b0;
            stat_q    <= '0;
            addr_hi_q <= '0;
            addr_q    <= '0;
            tx_load_q <= 1'b0;
            tx_data_q <= '0;
        end else begin
            tx_load_q <= 1'b0;
            if (frame_end_i) begin
                if (clr_q) begin
                    wel_q <= 1'b0;
                end
                clr_q <= 1'b0;
            end else if (byte_vld_i) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        case (byte_i)
                            OPC_WEN_SET: wel_q <= 1'b1;
                            OPC_WEN_CLR: clr_q <= 1'b1;
                            OPC_STAT_WR: clr_q <= 1'b1;
                            OPC_MEM_WR: begin
                                clr_q   <= 1'b1;
                                is_wr_q <= 1'b1;
                            end
                            OPC_MEM_RD: is_wr_q <= 1'b0;
                            OPC_STAT_RD: begin
                                tx_load_q <= 1'b1;
                                tx_data_q <= stat_word;
                            end
                            default: ;
                        endcase
                    end
                    ST_ADDR_HI: addr_hi_q <= byte_i;
                    ST_ADDR_LO: begin
                        if (is_wr_q) begin
                            addr_q <= start_addr;
                        end else begin
                            addr_q    <= start_addr + 1'b1;
                            tx_load_q <= 1'b1;
                            tx_data_q <= rd_data_i;
                        end
                    end
                    ST_STAT_RD: begin
                        tx_load_q <= 1'b1;
                        tx_data_q <= stat_word;
                    end
                    ST_STAT_WR: begin
                        if (wel_q) begin
                            stat_q <= byte_i[7:2];
                        end
                    end
                    ST_RD_DATA: begin
                        addr_q    <= addr_q + 1'b1;
                        tx_load_q <= 1'b1;
                        tx_data_q <= rd_data_i;
                    end
                    ST_WR_DATA: addr_q <= addr_q + 1'b1;
                    ST_IGNORE: ;
                endcase
            end
        end
    end

    assign rd_addr_o = (state_q == ST_ADDR_LO) ? start_addr : addr_q;
    assign we_o      = byte_vld_i && !frame_end_i && wel_q && (state_q == ST_WR_DATA);
    assign waddr_o   = addr_q;
    assign wdata_o   = byte_i;
    assign tx_load_o = tx_load_q;
    assign tx_data_o = tx_data_q;

    AST_WEL_ONLY_SET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(byte_vld_i && state_q == ST_OPCODE && byte_i == OPC_WEN_SET)); // R4
    AST_WEL_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && clr_q) |=> !wel_q); // R5
    AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wel_q) |-> $stable(stat_q)); // R7
    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (wel_q && !clr_q == 1'b0)); // R8

endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    logic              byte_vld;
    logic [7:0]        byte_val;
    logic              frame_end;
    logic              tx_load;
    logic [7:0]        tx_data;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              we;
    logic [MEM_AW-1:0] waddr;
    logic [7:0]        wdata;

    sermem_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
        .tx_load_i(tx_load), .tx_data_i(tx_data),
        .byte_vld_o(byte_vld), .byte_o(byte_val),
        .frame_end_o(frame_end), .miso_o(miso));

    sermem_ctrl #(.AW(MEM_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .byte_vld_i(byte_vld), .byte_i(byte_val), .frame_end_i(frame_end),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
        .tx_load_o(tx_load), .tx_data_o(tx_data));

    sermem_array #(.AW(MEM_AW), .DW(8)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data));

endmodule

// File: tb/sim_sermem_slave.sv
module sim_sermem_slave;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int errors = 0;
    int checks = 0;
    int miso_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    sermem_slave #(.MEM_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

    // R2: MISO may only move while SCK is low during a frame
    always @(miso) begin
        if (rst_n && !cs_n && sck) miso_bad++;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic f_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic f_end();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HP) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = d[i];
            repeat (HP) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
        xbits(d, 8, r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        f_begin();
        xbyte(op, r);
        f_end();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] d);
        logic [7:0] r;
        f_begin();
        xbyte(op, r);
        xbyte(d, r);
        f_end();
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic [7:0] r;
        f_begin();
        xbyte(8'h05, r);
        xbyte(8'h00, s);
        f_end();
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] first, input int n, input bit pattern);
        logic [7:0] r;
        f_begin();
        xbyte(8'h02, r);
        xbyte(a[15:8], r);
        xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(pattern ? 8'((i * 37 + 5) & 255) : first + 8'(i * 17), r);
        end
        f_end();
    endtask

    task automatic mem_read_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] r;
        f_begin();
        xbyte(8'h03, r);
        xbyte(a[15:8], r);
        xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            chk(req, r, model[(int'(a) + i) % DEPTH]);
        end
        f_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        end
        $finish;
    end

    initial begin
        logic [7:0] s, r;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3: reset state of status and array; R1 relies on MSB-first command
        rd_stat(s);
        chk("R3 status after reset", s, 8'h00);
        mem_read_chk(16'h0005, 2, "R3 array after reset");

        // R7: writes while flag clear
        cmd2(8'h01, 8'hFC);
        rd_stat(s);
        chk("R7 status write locked", s, 8'h00);
        mem_write(16'h0005, 8'hAA, 1, 1'b0);
        mem_read_chk(16'h0005, 1, "R7 memory write locked");

        // R4: set flag, repeated status bytes
        cmd1(8'h06);
        f_begin();
        xbyte(8'h05, r);
        xbyte(8'h00, s);
        chk("R4 status shows flag", s, 8'h02);
        xbyte(8'h00, s);
        chk("R4 status repeats", s, 8'h02);
        f_end();

        // R5: clear flag
        cmd1(8'h04);
        rd_stat(s);
        chk("R5 flag cleared", s, 8'h00);

        // R6: status write
        cmd1(8'h06);
        cmd2(8'h01, 8'hFD);
        rd_stat(s);
        chk("R6 status bits stored, bit0 zero, flag dropped", s, 8'hFC);
        cmd1(8'h06);
        cmd2(8'h01, 8'h02);
        rd_stat(s);
        chk("R6 data bit1 cannot keep flag", s, 8'h00);

        // R10: partial command byte dropped
        f_begin();
        xbits(8'h06, 7, r);
        f_end();
        rd_stat(s);
        chk("R10 partial byte discarded", s, 8'h00);

        // R11: unknown command then valid byte in same frame
        cmd2(8'hFF, 8'h06);
        rd_stat(s);
        chk("R11 unknown command ignores rest", s, 8'h00);
        cmd2(8'h06, 8'h04);
        rd_stat(s);
        chk("R11 byte after set command ignored", s, 8'h02);
        cmd1(8'h04);

        // R8: full burst write
        cmd1(8'h06);
        mem_write(16'h0000, 8'h00, DEPTH, 1'b1);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 37 + 5) & 255);
        rd_stat(s);
        chk("R8 flag cleared after write", s, 8'h00);

        // R9: full burst read
        mem_read_chk(16'h0000, DEPTH, "R9 burst read");

        // R8: upper address bits ignored
        cmd1(8'h06);
        mem_write(16'h1234, 8'h5A, 1, 1'b0);
        model[16'h1234 % DEPTH] = 8'h5A;
        mem_read_chk(16'h0034, 1, "R8 address masked");

        // R9: read wrap
        mem_read_chk(16'(DEPTH - 2), 4, "R9 read wraps");

        // R8: write wrap
        cmd1(8'h06);
        mem_write(16'(DEPTH - 1), 8'h11, 2, 1'b0);
        model[DEPTH - 1] = 8'h11;
        model[0] = 8'h22;
        mem_read_chk(16'(DEPTH - 1), 2, "R8 write wraps");

        // R7: burst without flag leaves array alone
        mem_write(16'h0008, 8'h99, 4, 1'b0);
        mem_read_chk(16'h0008, 4, "R7 burst write locked");

        // R2: MISO edge discipline
        chk("R2 miso changed while sck high", 8'(miso_bad), 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

endmodule